// File: doc/BRIEF.md
# Multi-Queue Packet-Ready Tracker

This block sits in front of a set of per-queue FIFOs that share one write port and one read port. Packet mode is chosen once, while reset is held. In that mode every 36-bit word can carry a start-of-packet flag in bit 34 and an end-of-packet flag in bit 33. Each queue keeps a count of the complete packets it holds. The read port signals data ready only when the selected queue holds at least one whole packet, so a consumer never starts on a packet that is still being written.

On the write side, a state machine keeps packets contiguous. While a packet is open it refuses any request to select another queue. In packet mode a queue change takes a fixed number of cycles, and writes offered during those cycles are dropped. In standard mode, selection takes effect at once and readiness depends only on whether the queue is empty. The write FSM has four states. W_IDLE means no queue is selected yet. W_SWITCH means a queue change is in progress. W_OPEN means a queue is selected and no packet is open. W_INPKT means a packet is open.

The transitions are as follows:
- W_IDLE or W_OPEN goes to W_SWITCH (packet mode) or to W_OPEN (standard mode) on a select.
- W_SWITCH goes to W_OPEN after SWITCH_CYC-1 cycles.
- W_OPEN goes to W_INPKT on a stored start word that has no end flag.
- W_INPKT goes to W_OPEN on a stored end word.

Top module: `pktq_tracker`

## Requirements
- R1: After reset, rd_valid_n and pkt_ready_n are 1, wr_full is 0, no write queue is selected and all queues are empty.
- R2: In standard mode (pkt_mode_in low during reset), a write select is accepted at one edge and a write at the next edge is stored. rd_valid_n is low whenever the selected read queue is non-empty, and pkt_ready_n stays high.
- R3: In packet mode, writes at the first and second edges after an accepted select are dropped, and a write at the third edge is stored in the new queue.
- R4: Bit 34 marks a packet start and bit 33 a packet end. A stored end word that follows a stored start word in the same queue completes a packet. A single stored word carrying both bits is a complete packet.
- R5: In packet mode, rd_valid_n and pkt_ready_n are low exactly when the selected read queue holds one or more complete packets, whatever the value of rd_en. When they are low, rd_data shows the queue's oldest word.
- R6: Reading out a counted end word decrements that queue's packet count. When the count reaches zero the outputs return high, even if partial-packet words remain.
- R7: An end word written while no packet is open is stored but never counted as a packet.
- R8: While a packet is open, a write select is ignored and later writes go to the same queue.
- R9: A write to a full queue is dropped, and wr_full shows that the selected write queue is full. A dropped end word does not complete a packet.
- R10: A select on either port takes priority over a write or read at the same edge, and that write or read is ignored.
- R11: pkt_mode_in is sampled only while rst_n is low. Changing it later has no effect.
- R12: rd_en while rd_valid_n is high removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_mode_in | input | 1 | Packet mode request, sampled during reset |
| wr_sel_valid | input | 1 | Request to select a write queue |
| wr_sel_q | input | QW | Write queue number |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write word, with flags in bits 34 and 33 |
| wr_full | output | 1 | Selected write queue is full |
| rd_sel_valid | input | 1 | Request to select a read queue |
| rd_sel_q | input | QW | Read queue number |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Oldest word of the selected read queue |
| rd_valid_n | output | 1 | Data available, active low |
| pkt_ready_n | output | 1 | Complete packet available (packet mode), active low |

## Verification
The counting logic is exercised with several word patterns:
- A clean start, payload, end sequence.
- A stray end word with no open packet.
- A single word that carries both flags.
- A partial packet left waiting.

Each pattern separates counting by flags from counting by word occupancy. A select during an open packet is checked by where the later words land. The switch delay is checked by which of three consecutive writes reaches the new queue. A full queue offered its end word, and a standard-mode run with flagged words, show that only stored, properly opened end words make a queue ready.

// File: rtl/pktq_pkg.sv
package pktq_pkg;
    // Flag positions inside each stored word
    localparam int SOP_BIT = 34;
    localparam int EOP_BIT = 33;

    typedef enum logic [1:0] {
        W_IDLE,
        W_SWITCH,
        W_OPEN,
        W_INPKT
    } wr_state_t;
endpackage

// File: rtl/pktq_lane.sv
module pktq_lane #(
    parameter int DW    = 36,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_word,
    input  logic          push_tag,
    input  logic          pop,
    output logic [DW-1:0] head_word,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] pkt_cnt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] occ;
    logic          push_ok, pop_ok, head_tag;

    assign empty    = (occ == '0);
    assign full     = (occ == CW'(DEPTH));
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign head_word = mem[rp][DW-1:0];
    assign head_tag  = mem[rp][DW];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= {push_tag, push_word};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            occ     <= '0;
            pkt_cnt <= '0;
        end else begin
            if (push_ok) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop_ok) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            occ     <= occ + CW'(push_ok) - CW'(pop_ok);
            pkt_cnt <= pkt_cnt + CW'(push_ok && push_tag) - CW'(pop_ok && head_tag);
        end
    end
endmodule

// File: rtl/pktq_wr_fsm.sv
module pktq_wr_fsm
    import pktq_pkg::*;
#(
    parameter int NQ         = 4,
    parameter int QW         = $clog2(NQ),
    parameter int SWITCH_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_mode,
    input  logic          sel_valid,
    input  logic [QW-1:0] sel_q,
    input  logic          wr_en,
    input  logic          sop,
    input  logic          eop,
    input  logic          cur_full,
    output wr_state_t     st,
    output logic [QW-1:0] cur_q,
    output logic          have_q,
    output logic          push,
    output logic          push_tag
);
    localparam int WAIT = SWITCH_CYC - 1;
    localparam int WCW  = (WAIT > 1) ? $clog2(WAIT + 1) : 1;

    wr_state_t      st_nx;
    logic [WCW-1:0] wait_cnt;
    logic           sel_take;

    assign sel_take = sel_valid && (st == W_IDLE || st == W_OPEN);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= W_IDLE;
            cur_q    <= '0;
            wait_cnt <= '0;
        end else begin
            st <= st_nx;
            if (sel_take) begin
                cur_q <= sel_q;
            end
            if (st == W_SWITCH) begin
                wait_cnt <= wait_cnt + 1'b1;
            end else begin
                wait_cnt <= '0;
            end
        end
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            W_IDLE: begin
                if (sel_take) st_nx = pkt_mode ? W_SWITCH : W_OPEN;
            end
            W_SWITCH: begin
                if (wait_cnt == WCW'(WAIT - 1)) st_nx = W_OPEN;
            end
            W_OPEN: begin
                if (sel_take) begin
                    st_nx = pkt_mode ? W_SWITCH : W_OPEN;
                end else if (push && pkt_mode && sop && !eop) begin
                    st_nx = W_INPKT;
                end
            end
            W_INPKT: begin
                if (push && eop) st_nx = W_OPEN;
            end
            default: st_nx = W_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        push     = 1'b0;
        push_tag = 1'b0;
        have_q   = 1'b1;
        unique case (st)
            W_IDLE:   have_q = 1'b0;
            W_SWITCH: ;
            W_OPEN: begin
                push     = wr_en && !sel_take && !cur_full;
                push_tag = pkt_mode && sop && eop;
            end
            W_INPKT: begin
                push     = wr_en && !cur_full;
                push_tag = eop;
            end
            default: have_q = 1'b0;
        endcase
    end
endmodule

// File: rtl/pktq_tracker.sv
module pktq_tracker
    import pktq_pkg::*;
#(
    parameter int NQ         = 4,
    parameter int DEPTH      = 4,
    parameter int DW         = 36,
    parameter int SWITCH_CYC = 3,
    parameter int QW         = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_mode_in,
    input  logic          wr_sel_valid,
    input  logic [QW-1:0] wr_sel_q,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    input  logic          rd_sel_valid,
    input  logic [QW-1:0] rd_sel_q,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid_n,
    output logic          pkt_ready_n
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          mode_q;
    wr_state_t     wst;
    logic [QW-1:0] cur_q;
    logic          have_q, push, push_tag, cur_full;
    logic [QW-1:0] rd_q;
    logic          rd_ok, avail, pop, sel_empty;

    logic [DW-1:0] lane_head  [NQ];
    logic          lane_empty [NQ];
    logic          lane_full  [NQ];
    logic [CW-1:0] lane_cnt   [NQ];

    // Mode is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= pkt_mode_in;
    end

    assign cur_full = lane_full[cur_q];
    assign wr_full  = have_q && cur_full;

    pktq_wr_fsm #(.NQ(NQ), .QW(QW), .SWITCH_CYC(SWITCH_CYC)) u_wr (
        .clk(clk), .rst_n(rst_n), .pkt_mode(mode_q),
        .sel_valid(wr_sel_valid), .sel_q(wr_sel_q), .wr_en(wr_en),
        .sop(wr_data[SOP_BIT]), .eop(wr_data[EOP_BIT]), .cur_full(cur_full),
        .st(wst), .cur_q(cur_q), .have_q(have_q), .push(push), .push_tag(push_tag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            rd_ok <= 1'b0;
        end else if (rd_sel_valid) begin
            rd_q  <= rd_sel_q;
            rd_ok <= 1'b1;
        end
    end

    assign sel_empty   = lane_empty[rd_q];
    assign avail       = rd_ok && (mode_q ? (lane_cnt[rd_q] != '0) : !sel_empty);
    assign pop         = rd_en && avail && !rd_sel_valid;
    assign rd_data     = lane_head[rd_q];
    assign rd_valid_n  = !avail;
    assign pkt_ready_n = !(mode_q && avail);

    for (genvar g = 0; g < NQ; g++) begin : g_lane
        pktq_lane #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .push(push && (cur_q == QW'(g))), .push_word(wr_data), .push_tag(push_tag),
            .pop(pop && (rd_q == QW'(g))),
            .head_word(lane_head[g]), .empty(lane_empty[g]), .full(lane_full[g]),
            .pkt_cnt(lane_cnt[g])
        );
    end
endmodule

// File: rtl/pktq_tracker_chk.sv
module pktq_tracker_chk
    import pktq_pkg::*;
#(
    parameter int QW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_q,
    input wr_state_t     wst,
    input logic [QW-1:0] cur_q,
    input logic          push,
    input logic          push_tag,
    input logic          cur_full,
    input logic          rd_ok,
    input logic [QW-1:0] rd_q,
    input logic          rd_sel_valid,
    input logic          sel_empty,
    input logic          rd_valid_n,
    input logic          pkt_ready_n
);
    p_std_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> pkt_ready_n);

    p_switch_holds_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wst == W_SWITCH) |=> $stable(cur_q));

    p_tag_makes_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && push && push_tag && rd_ok && rd_q == cur_q && !rd_sel_valid) |=> !pkt_ready_n);

    p_valid_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_n |-> !sel_empty);

    p_lock_in_pkt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wst == W_INPKT) |=> $stable(cur_q));

    p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !cur_full);

    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));
endmodule

bind pktq_tracker pktq_tracker_chk #(.QW(QW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .wst(wst), .cur_q(cur_q),
    .push(push), .push_tag(push_tag), .cur_full(cur_full), .rd_ok(rd_ok),
    .rd_q(rd_q), .rd_sel_valid(rd_sel_valid), .sel_empty(sel_empty),
    .rd_valid_n(rd_valid_n), .pkt_ready_n(pkt_ready_n)
);

// File: tb/test_pktq_tracker.sv
module test_pktq_tracker;
    localparam int PERIOD = 10;
    localparam int NQ = 4, DEPTH = 4, DW = 36, QW = 2;
    localparam logic [DW-1:0] S = 36'h4_0000_0000;
    localparam logic [DW-1:0] E = 36'h2_0000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_mode_in = 1'b1;
    logic          wr_sel_valid = 1'b0, wr_en = 1'b0;
    logic [QW-1:0] wr_sel_q = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_sel_valid = 1'b0, rd_en = 1'b0;
    logic [QW-1:0] rd_sel_q = '0;
    logic          wr_full, rd_valid_n, pkt_ready_n;
    logic [DW-1:0] rd_data;

    int n_chk = 0, n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    pktq_tracker #(.NQ(NQ), .DEPTH(DEPTH), .DW(DW), .SWITCH_CYC(3)) i_pktq_tracker (
        .clk(clk), .rst_n(rst_n), .pkt_mode_in(pkt_mode_in),
        .wr_sel_valid(wr_sel_valid), .wr_sel_q(wr_sel_q), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .rd_sel_valid(rd_sel_valid), .rd_sel_q(rd_sel_q), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid_n(rd_valid_n), .pkt_ready_n(pkt_ready_n)
    );

    typedef struct packed {
        logic          ws_v;
        logic [1:0]    ws_q;
        logic          we;
        logic [35:0]   wd;
        logic          rs_v;
        logic [1:0]    rs_q;
        logic          re;
        logic          ev_n;
        logic          er_n;
        logic          cd;
        logic [35:0]   ed;
    } vec_t;

    localparam int NV = 28;
    // ws_v ws_q we wd | rs_v rs_q re | exp valid_n ready_n | check data, data
    localparam vec_t VT [NV] = '{
        '{1'b0,2'd0,1'b0,36'h0,       1'b1,2'd1,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 0 read q1, empty (R5)
        '{1'b1,2'd1,1'b0,36'h0,       1'b0,2'd0,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 1 write select q1 (R3)
        '{1'b0,2'd0,1'b1,S|36'hA1,    1'b0,2'd0,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 2 dropped (R3)
        '{1'b0,2'd0,1'b1,S|36'hA2,    1'b0,2'd0,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 3 dropped (R3)
        '{1'b0,2'd0,1'b1,S|36'h11,    1'b0,2'd0,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 4 stored, open (R4)
        '{1'b1,2'd2,1'b0,36'h0,       1'b0,2'd0,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 5 select ignored (R8)
        '{1'b0,2'd0,1'b1,36'h12,      1'b0,2'd0,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 6 payload to q1 (R8)
        '{1'b0,2'd0,1'b1,E|36'h13,    1'b0,2'd0,1'b0, 1'b0,1'b0, 1'b1,S|36'h11},     // 7 packet done (R4 R5)
        '{1'b0,2'd0,1'b0,36'h0,       1'b0,2'd0,1'b1, 1'b0,1'b0, 1'b1,36'h12},       // 8 read (R5)
        '{1'b0,2'd0,1'b0,36'h0,       1'b0,2'd0,1'b0, 1'b0,1'b0, 1'b1,36'h12},       // 9 no rd_en, still ready (R5)
        '{1'b0,2'd0,1'b0,36'h0,       1'b0,2'd0,1'b1, 1'b0,1'b0, 1'b1,E|36'h13},     // 10 read (R5)
        '{1'b0,2'd0,1'b0,36'h0,       1'b0,2'd0,1'b1, 1'b1,1'b1, 1'b0,36'h0},        // 11 end read out (R6)
        '{1'b0,2'd0,1'b1,E|36'h21,    1'b0,2'd0,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 12 stray end (R7)
        '{1'b0,2'd0,1'b1,S|E|36'h22,  1'b0,2'd0,1'b0, 1'b0,1'b0, 1'b1,E|36'h21},     // 13 one-word packet (R4 R7)
        '{1'b0,2'd0,1'b0,36'h0,       1'b0,2'd0,1'b1, 1'b0,1'b0, 1'b1,S|E|36'h22},   // 14 stray end read, count kept (R7)
        '{1'b0,2'd0,1'b0,36'h0,       1'b0,2'd0,1'b1, 1'b1,1'b1, 1'b0,36'h0},        // 15 (R6)
        '{1'b0,2'd0,1'b1,S|36'h31,    1'b0,2'd0,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 16 partial held back (R6)
        '{1'b0,2'd0,1'b0,36'h0,       1'b0,2'd0,1'b1, 1'b1,1'b1, 1'b0,36'h0},        // 17 read while not ready (R12)
        '{1'b0,2'd0,1'b1,E|36'h32,    1'b0,2'd0,1'b0, 1'b0,1'b0, 1'b1,S|36'h31},     // 18 nothing lost (R12)
        '{1'b0,2'd0,1'b0,36'h0,       1'b1,2'd2,1'b0, 1'b1,1'b1, 1'b0,36'h0},        // 19 read q2 (R5)
        '{1'b0,2'd0,1'b0,36'h0,       1'b1,2'd1,1'b0, 1'b0,1'b0, 1'b1,S|36'h31},     // 20 back to q1 (R5)
        '{1'b0,2'd0,1'b0,36'h0,       1'b1,2'd1,1'b1, 1'b0,1'b0, 1'b1,S|36'h31},     // 21 select beats read (R10)
        '{1'b0,2'd0,1'b0,36'h0,       1'b0,2'd0,1'b1, 1'b0,1'b0, 1'b1,E|36'h32},     // 22 read (R5)
        '{1'b1,2'd2,1'b0,36'h0,       1'b0,2'd0,1'b0, 1'b0,1'b0, 1'b1,E|36'h32},     // 23 select q2 (R3)
        '{1'b0,2'd0,1'b1,S|E|36'h41,  1'b0,2'd0,1'b0, 1'b0,1'b0, 1'b1,E|36'h32},     // 24 dropped (R3)
        '{1'b0,2'd0,1'b1,S|E|36'h43,  1'b0,2'd0,1'b0, 1'b0,1'b0, 1'b1,E|36'h32},     // 25 dropped (R3)
        '{1'b0,2'd0,1'b1,S|E|36'h42,  1'b0,2'd0,1'b0, 1'b0,1'b0, 1'b1,E|36'h32},     // 26 stored (R3)
        '{1'b0,2'd0,1'b0,36'h0,       1'b1,2'd2,1'b0, 1'b0,1'b0, 1'b1,S|E|36'h42}    // 27 third write landed (R3)
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_sel_valid = 1'b0; wr_en = 1'b0; rd_sel_valid = 1'b0; rd_en = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #(PERIOD/4);
        idle();
    endtask

    task automatic do_reset(input logic mode);
        idle();
        pkt_mode_in = mode;
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
    endtask

    task automatic wsel(input logic [1:0] q);
        wr_sel_valid = 1'b1; wr_sel_q = q; step();
    endtask

    task automatic wr(input logic [35:0] d);
        wr_en = 1'b1; wr_data = d; step();
    endtask

    task automatic rsel(input logic [1:0] q);
        rd_sel_valid = 1'b1; rd_sel_q = q; step();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD/4);
        do_reset(1'b1);
        // R1: reset state
        check("R1 valid_n", 64'(rd_valid_n), 64'd1);
        check("R1 ready_n", 64'(pkt_ready_n), 64'd1);
        check("R1 wr_full", 64'(wr_full), 64'd0);

        for (int i = 0; i < NV; i++) begin
            wr_sel_valid = VT[i].ws_v; wr_sel_q = VT[i].ws_q;
            wr_en = VT[i].we; wr_data = VT[i].wd;
            rd_sel_valid = VT[i].rs_v; rd_sel_q = VT[i].rs_q; rd_en = VT[i].re;
            step();
            check($sformatf("R5 table %0d valid_n", i), 64'(rd_valid_n), 64'(VT[i].ev_n));
            check($sformatf("R4 table %0d ready_n", i), 64'(pkt_ready_n), 64'(VT[i].er_n));
            if (VT[i].cd) check($sformatf("R5 table %0d data", i), 64'(rd_data), 64'(VT[i].ed));
        end

        // R9: fill q3 with an open packet, then offer its end word
        wsel(2'd3); step(); step();
        wr(S | 36'h51); wr(36'h52); wr(36'h53);
        check("R9 not yet full", 64'(wr_full), 64'd0);
        wr(36'h54);
        check("R9 full", 64'(wr_full), 64'd1);
        wr(E | 36'h55);
        rsel(2'd3);
        check("R9 dropped end not counted", 64'(pkt_ready_n), 64'd1);

        // R2 / R11: standard mode, mode input changed after reset
        do_reset(1'b0);
        pkt_mode_in = 1'b1;
        wsel(2'd0);
        wr(S | E | 36'h7);
        wr(36'h8);
        rsel(2'd0);
        check("R2 valid_n", 64'(rd_valid_n), 64'd0);
        check("R11 ready_n stays high", 64'(pkt_ready_n), 64'd1);
        check("R2 data", 64'(rd_data), 64'(S | E | 36'h7));
        rd_en = 1'b1; step();
        check("R2 fifo order", 64'(rd_data), 64'h8);
        rd_en = 1'b1; step();
        check("R2 empty after reads", 64'(rd_valid_n), 64'd1);

        // R10: write at the select edge is ignored
        wr_sel_valid = 1'b1; wr_sel_q = 2'd2; wr_en = 1'b1; wr_data = 36'h9; step();
        rsel(2'd2);
        check("R10 write dropped", 64'(rd_valid_n), 64'd1);
        wr(36'hA);
        check("R10 next write stored", 64'(rd_data), 64'hA);
        check("R2 valid after write", 64'(rd_valid_n), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule